// File: doc/BRIEF.md
# Host Programmed-I/O Byte Buffer

This block is a 128-byte first-in first-out buffer. It sits between a host I/O data port and a SCSI-side byte engine, and it carries programmed-I/O data in either direction. A direction input picks the roles of the two sides:

- **Receive:** the SCSI side fills the buffer over a valid/ready byte handshake, and the host drains it.
- **Transmit:** the host fills the buffer and the SCSI side drains it.

The host moves data one byte per access or as a packed 32-bit word holding four bytes.

The host status byte reports how full the buffer is as a coarse 4-bit band code rather than an exact count. From this code the host knows how many bytes it can move in a burst without checking status between bytes. The same byte also carries a sticky access-error flag, a pass-through interrupt-pending flag and a mode bit. An enable register, cleared by reset, gates the error and interrupt flags onto a host interrupt line.

Top module: `hpio_buffer`

## Requirements
- R1: After reset the status byte reads 0x10 (empty code, no error, no interrupt, mode bit 0), `host_irq` is low, and the enable register is zero.
- R2: Status bits [4:1] hold the fill band, so the status byte shows the band in the mask 0x1E. The values are: 0 bytes → 0x10; 1–43 bytes → 0x00; 44–85 bytes → 0x08; 86–127 bytes → 0x0C; 128 bytes → 0x0E. Bit 5 always reads 0.
- R3: A byte access (`host_word`=0) moves one byte, and bytes leave in the order they entered.
- R4: A word access (`host_word`=1) moves four consecutive bytes in little-endian order. Bits [7:0] hold the byte that is first in time, and bits [31:24] hold the byte that is last.
- R5: Some host accesses are ignored, leave the buffer unchanged and set the error flag (status bit 7). These are: a word read with fewer than 4 bytes stored, a word write with fewer than 4 bytes free, a byte read from an empty buffer, and a byte write to a full buffer.
- R6: The error flag holds until the status register is written. A write to the status register clears the flag and loads status bit 0 (1 = programmed I/O, 0 = DMA) from bit 0 of the written value.
- R7: Status bit 6 shows the `scsi_int` input.
- R8: When `dir_rx`=1, host writes have no effect and `scsi_out_valid` is low. When `dir_rx`=0, host reads neither remove data nor set the error flag, `scsi_in_ready` is low, and `scsi_out_valid` is high whenever the buffer holds data.
- R9: `host_irq` = (enable bit 0 AND status bit 6) OR (enable bit 1 AND status bit 7).
- R10: The capacity is 128 bytes. When the buffer is full, `scsi_in_ready` is low and a byte offered by the SCSI side is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_rx | input | 1 | 1 = SCSI fills and host drains; 0 = host fills and SCSI drains |
| host_rd_en | input | 1 | Host read of the data port |
| host_wr_en | input | 1 | Host write of the data port |
| host_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| host_wdata | input | 32 | Host write data (byte accesses use bits [7:0]) |
| host_rdata | output | 32 | Next four stored bytes, oldest in [7:0] |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 8 | Status write value (bit 0 = mode) |
| stat_rdata | output | 8 | Status byte |
| ien_wr | input | 1 | Write strobe for the enable register |
| ien_wdata | input | 8 | Enable register value |
| host_irq | output | 1 | Host interrupt request |
| scsi_int | input | 1 | Interrupt pending from the SCSI engine |
| scsi_in_valid | input | 1 | SCSI byte offered (receive) |
| scsi_in_data | input | 8 | SCSI byte in |
| scsi_in_ready | output | 1 | Buffer accepts a SCSI byte |
| scsi_out_valid | output | 1 | Byte available to the SCSI side (transmit) |
| scsi_out_data | output | 8 | Oldest stored byte |
| scsi_out_ready | input | 1 | SCSI side takes the byte |

## Verification
Outputs show state with no added delay:

- `host_rdata` and `scsi_out_data` come straight from the head of the buffer. They are therefore correct in the cycle the read strobe is high, and the bench samples them before the edge that consumes them.
- The status byte, `scsi_in_ready` and `host_irq` follow the registered fill count, error flag and enables. Each changes one edge after the access or register write that causes it, so the bench checks these after the following falling edge.
- Status bit 6 passes through with no register, so it is checked in the same cycle its input is driven.

Every band boundary is reached one byte at a time, so each threshold is seen on both sides.

// File: rtl/hpio_pkg.sv
package hpio_pkg;

    localparam int FIFO_DEPTH   = 128;
    localparam int WORD_BYTES   = 4;
    localparam int LVL_LOW_MAX  = 43;
    localparam int LVL_MID_MAX  = 85;

    typedef enum logic [3:0] {
        LVL_EMPTY = 4'b1000,
        LVL_LOW   = 4'b0000,
        LVL_MID   = 4'b0100,
        LVL_HIGH  = 4'b0110,
        LVL_FULL  = 4'b0111
    } lvl_code_e;

    typedef struct packed {
        logic      err;
        logic      intp;
        logic      rsvd;
        lvl_code_e lvl;
        logic      pio;
    } host_stat_t;

endpackage

// File: rtl/hpio_store.sv
module hpio_store #(
    parameter int DEPTH = hpio_pkg::FIFO_DEPTH,
    parameter int LANES = hpio_pkg::WORD_BYTES,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NW-1:0]      push_n,
    input  logic [8*LANES-1:0] push_data,
    input  logic [NW-1:0]      pop_n,
    output logic [8*LANES-1:0] head_data,
    output logic [CW-1:0]      fill
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        for (int ln = 0; ln < LANES; ln++) begin
            if (NW'(ln) < push_n)
                mem[wr_ptr + AW'(ln)] <= push_data[8*ln +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            fill   <= fill + CW'(push_n) - CW'(pop_n);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head_data[8*g +: 8] = mem[rd_ptr + AW'(g)];
    end
endmodule

// File: rtl/hpio_level.sv
module hpio_level
    import hpio_pkg::*;
#(
    parameter int DEPTH   = FIFO_DEPTH,
    parameter int LOW_MAX = LVL_LOW_MAX,
    parameter int MID_MAX = LVL_MID_MAX,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] fill,
    output lvl_code_e     code
);
    always_comb begin
        if (fill == '0)                  code = LVL_EMPTY;
        else if (fill <= CW'(LOW_MAX))   code = LVL_LOW;
        else if (fill <= CW'(MID_MAX))   code = LVL_MID;
        else if (fill <  CW'(DEPTH))     code = LVL_HIGH;
        else                             code = LVL_FULL;
    end
endmodule

// File: rtl/hpio_buffer.sv
module hpio_buffer
    import hpio_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int LANES = WORD_BYTES,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(LANES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dir_rx,
    input  logic        host_rd_en,
    input  logic        host_wr_en,
    input  logic        host_word,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    input  logic        stat_wr,
    input  logic [7:0]  stat_wdata,
    output logic [7:0]  stat_rdata,
    input  logic        ien_wr,
    input  logic [7:0]  ien_wdata,
    output logic        host_irq,
    input  logic        scsi_int,
    input  logic        scsi_in_valid,
    input  logic [7:0]  scsi_in_data,
    output logic        scsi_in_ready,
    output logic        scsi_out_valid,
    output logic [7:0]  scsi_out_data,
    input  logic        scsi_out_ready
);
    logic [CW-1:0]      fill;
    logic [8*LANES-1:0] head;
    logic [NW-1:0]      need, push_n, pop_n;
    logic [NW-1:0]      host_push_n, host_pop_n;
    logic [8*LANES-1:0] push_data;
    logic               host_rd_req, host_wr_req, rd_ok, wr_ok, bad_access;
    logic               scsi_push, scsi_pop;
    logic               err_q, pio_q;
    logic [7:0]         ien_q;
    lvl_code_e          lvl;
    host_stat_t         stat;

    assign need        = host_word ? NW'(LANES) : NW'(1);
    assign host_rd_req = host_rd_en & dir_rx;
    assign host_wr_req = host_wr_en & ~dir_rx;
    assign rd_ok       = fill >= CW'(need);
    assign wr_ok       = (CW'(DEPTH) - fill) >= CW'(need);
    assign bad_access  = (host_rd_req & ~rd_ok) | (host_wr_req & ~wr_ok);

    assign scsi_in_ready  = dir_rx & (fill != CW'(DEPTH));
    assign scsi_out_valid = ~dir_rx & (fill != '0);
    assign scsi_push      = scsi_in_valid & scsi_in_ready;
    assign scsi_pop       = scsi_out_ready & scsi_out_valid;

    assign host_pop_n  = (host_rd_req & rd_ok) ? need : '0;
    assign host_push_n = (host_wr_req & wr_ok) ? need : '0;

    always_comb begin
        if (dir_rx) begin
            push_n    = scsi_push ? NW'(1) : '0;
            push_data = {{(8*LANES-8){1'b0}}, scsi_in_data};
            pop_n     = host_pop_n;
        end else begin
            push_n    = host_push_n;
            push_data = host_wdata;
            pop_n     = scsi_pop ? NW'(1) : '0;
        end
    end

    hpio_store #(.DEPTH(DEPTH), .LANES(LANES)) store_i (
        .clk       (clk),
        .rst       (rst),
        .push_n    (push_n),
        .push_data (push_data),
        .pop_n     (pop_n),
        .head_data (head),
        .fill      (fill)
    );

    hpio_level #(.DEPTH(DEPTH)) level_i (
        .fill (fill),
        .code (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
            pio_q <= 1'b0;
            ien_q <= '0;
        end else begin
            if (bad_access)   err_q <= 1'b1;
            else if (stat_wr) err_q <= 1'b0;
            if (stat_wr)      pio_q <= stat_wdata[0];
            if (ien_wr)       ien_q <= ien_wdata;
        end
    end

    always_comb begin
        stat.err  = err_q;
        stat.intp = scsi_int;
        stat.rsvd = 1'b0;
        stat.lvl  = lvl;
        stat.pio  = pio_q;
    end

    assign stat_rdata    = stat;
    assign host_rdata    = head;
    assign scsi_out_data = head[7:0];
    assign host_irq      = (ien_q[0] & stat.intp) | (ien_q[1] & stat.err);
endmodule

// File: rtl/hpio_buffer_chk.sv
module hpio_buffer_chk (
    input logic        clk,
    input logic        rst,
    input logic        dir_rx,
    input logic        host_rd_en,
    input logic        host_word,
    input logic        stat_wr,
    input logic [7:0]  stat_rdata,
    input logic        scsi_int,
    input logic        scsi_in_ready,
    input logic        scsi_out_valid,
    input logic        host_irq
);
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata[4:1] == 4'h8 || stat_rdata[4:1] == 4'h0 || stat_rdata[4:1] == 4'h4 ||
         stat_rdata[4:1] == 4'h6 || stat_rdata[4:1] == 4'h7) && !stat_rdata[5]); // R2

    AST_FULL_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata[4:1] == 4'h7) |-> !scsi_in_ready); // R10

    AST_SHORT_WORD_ERR: assert property (@(posedge clk) disable iff (rst)
        (dir_rx && host_rd_en && host_word && stat_rdata[4:1] == 4'h8) |=> stat_rdata[7]); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata[7] && !stat_wr) |=> stat_rdata[7]); // R6

    AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (stat_rdata[4:1] == 4'h8 || dir_rx) |-> !scsi_out_valid); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> (stat_rdata[6] || stat_rdata[7])); // R9

    AST_INT_SEEN: assert property (@(posedge clk) disable iff (rst)
        $rose(scsi_int) |-> stat_rdata[6]); // R7
endmodule

bind hpio_buffer hpio_buffer_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .dir_rx         (dir_rx),
    .host_rd_en     (host_rd_en),
    .host_word      (host_word),
    .stat_wr        (stat_wr),
    .stat_rdata     (stat_rdata),
    .scsi_int       (scsi_int),
    .scsi_in_ready  (scsi_in_ready),
    .scsi_out_valid (scsi_out_valid),
    .host_irq       (host_irq)
);

// File: tb/hpio_buffer_tb_top.sv
module hpio_buffer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_rx = 1'b1;
    logic        host_rd_en = 1'b0, host_wr_en = 1'b0, host_word = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        stat_wr = 1'b0;
    logic [7:0]  stat_wdata = '0;
    logic [7:0]  stat_rdata;
    logic        ien_wr = 1'b0;
    logic [7:0]  ien_wdata = '0;
    logic        host_irq;
    logic        scsi_int = 1'b0;
    logic        scsi_in_valid = 1'b0;
    logic [7:0]  scsi_in_data = '0;
    logic        scsi_in_ready, scsi_out_valid;
    logic [7:0]  scsi_out_data;
    logic        scsi_out_ready = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    logic mode = 1'b0;

    always #2 clk = ~clk;

    hpio_buffer dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic scsi_push(input logic [7:0] b);
        scsi_in_valid = 1'b1; scsi_in_data = b;
        step();
        scsi_in_valid = 1'b0;
    endtask

    task automatic host_read(input logic word, output logic [31:0] d);
        host_rd_en = 1'b1; host_word = word;
        #1 d = host_rdata;
        step();
        host_rd_en = 1'b0; host_word = 1'b0;
    endtask

    task automatic host_write(input logic word, input logic [31:0] d);
        host_wr_en = 1'b1; host_word = word; host_wdata = d;
        step();
        host_wr_en = 1'b0; host_word = 1'b0;
    endtask

    task automatic stat_write(input logic [7:0] v);
        stat_wr = 1'b1; stat_wdata = v;
        step();
        stat_wr = 1'b0;
        mode = v[0];
    endtask

    task automatic t_reset();
        chk("R1 status", {24'h0, stat_rdata}, 32'h10);
        chk("R1 irq", {31'h0, host_irq}, 32'h0);
        chk("R1 ready", {31'h0, scsi_in_ready}, 32'h1);
        chk("R8 out_valid rx", {31'h0, scsi_out_valid}, 32'h0);
    endtask

    task automatic t_rx_bytes();
        logic [31:0] d;
        scsi_push(8'hA1); scsi_push(8'hA2); scsi_push(8'hA3);
        chk("R2 low band", {24'h0, stat_rdata}, 32'h00);
        host_read(1'b0, d); chk("R3 byte0", {24'h0, d[7:0]}, 32'hA1);
        host_read(1'b0, d); chk("R3 byte1", {24'h0, d[7:0]}, 32'hA2);
        host_read(1'b0, d); chk("R3 byte2", {24'h0, d[7:0]}, 32'hA3);
        chk("R3 empty after", {24'h0, stat_rdata}, 32'h10);
        host_write(1'b0, 32'h55);
        chk("R8 host write ignored in rx", {24'h0, stat_rdata}, 32'h10);
    endtask

    task automatic t_word_rx();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) scsi_push(8'h11 + 8'(i));
        host_read(1'b1, d); chk("R4 word LE", d, 32'h14131211);
        chk("R4 one left", {24'h0, stat_rdata}, 32'h00);
        host_read(1'b1, d);
        chk("R5 short word read err", {24'h0, stat_rdata}, 32'h80);
        step();
        chk("R6 err sticky", {24'h0, stat_rdata}, 32'h80);
        host_read(1'b0, d); chk("R5 data kept", {24'h0, d[7:0]}, 32'h15);
        host_read(1'b0, d);
        chk("R5 empty byte read err", {24'h0, stat_rdata}, 32'h90);
        stat_write(8'h01);
        chk("R6 clear and mode", {24'h0, stat_rdata}, 32'h11);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        for (int i = 0; i < 128; i++) begin
            scsi_push(8'(i));
            if (i + 1 == 43)  chk("R2 43", {24'h0, stat_rdata}, 32'h01);
            if (i + 1 == 44)  chk("R2 44", {24'h0, stat_rdata}, 32'h09);
            if (i + 1 == 85)  chk("R2 85", {24'h0, stat_rdata}, 32'h09);
            if (i + 1 == 86)  chk("R2 86", {24'h0, stat_rdata}, 32'h0D);
            if (i + 1 == 127) chk("R2 127", {24'h0, stat_rdata}, 32'h0D);
        end
        chk("R2 full", {24'h0, stat_rdata}, 32'h0F);
        chk("R10 ready low", {31'h0, scsi_in_ready}, 32'h0);
        scsi_push(8'hFF);
        chk("R10 push refused", {24'h0, stat_rdata}, 32'h0F);
        for (int w = 0; w < 32; w++) begin
            host_read(1'b1, d);
            chk("R4 drain word", d, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
        end
        chk("R10 drained", {24'h0, stat_rdata}, 32'h11);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        dir_rx = 1'b0;
        #1 chk("R8 ready low tx", {31'h0, scsi_in_ready}, 32'h0);
        host_write(1'b1, 32'hDDCCBBAA);
        host_write(1'b0, 32'h000000EE);
        chk("R8 out_valid", {31'h0, scsi_out_valid}, 32'h1);
        host_read(1'b1, d);
        chk("R8 host read ignored in tx", {24'h0, stat_rdata}, 32'h01);
        for (int i = 0; i < 5; i++) begin
            scsi_out_ready = 1'b1;
            #1 chk("R4 tx byte order", {24'h0, scsi_out_data}, 32'(8'hAA + 8'(i * 17)));
            step();
            scsi_out_ready = 1'b0;
        end
        chk("R8 out_valid empty", {31'h0, scsi_out_valid}, 32'h0);
        for (int w = 0; w < 32; w++) host_write(1'b1, 32'h01010101 * 32'(w));
        chk("R2 tx full", {24'h0, stat_rdata}, 32'h0F);
        host_write(1'b1, 32'h12345678);
        chk("R5 word write full err", {24'h0, stat_rdata}, 32'h8F);
        ien_wr = 1'b1; ien_wdata = 8'h02; step(); ien_wr = 1'b0;
        chk("R9 irq on err", {31'h0, host_irq}, 32'h1);
        stat_write(8'h01);
        chk("R9 irq drops", {31'h0, host_irq}, 32'h0);
        scsi_out_ready = 1'b1;
        for (int i = 0; i < 128; i++) begin
            #1 if (i % 16 == 0) chk("R3 tx drain", {24'h0, scsi_out_data}, 32'(i / 4));
            step();
        end
        scsi_out_ready = 1'b0;
        chk("R2 tx empty", {24'h0, stat_rdata}, 32'h11);
        dir_rx = 1'b1;
    endtask

    task automatic t_int();
        scsi_int = 1'b1;
        #1 chk("R7 int flag", {24'h0, stat_rdata}, 32'h51);
        chk("R9 irq gated", {31'h0, host_irq}, 32'h0);
        ien_wr = 1'b1; ien_wdata = 8'h01; step(); ien_wr = 1'b0;
        chk("R9 irq on int", {31'h0, host_irq}, 32'h1);
        scsi_int = 1'b0;
        #1 chk("R7 int clear", {24'h0, stat_rdata}, 32'h11);
    endtask

    initial begin
        fork
            begin
                repeat (3) step();
                rst = 1'b0;
                step();
                t_reset();
                t_rx_bytes();
                t_word_rx();
                t_levels();
                t_tx();
                t_int();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule